// File: doc/BRIEF.md
# Two-Controller Interrupt Request Capture

This block latches sixteen interrupt lines into two request registers of eight bits each. Lines 0 to 7 belong to a primary controller and lines 8 to 15 to a secondary controller. Each line can be set to edge or level behaviour through a small two-byte trigger-mode store. Activity on the secondary controller is folded onto a cascade bit of the primary. A flag per controller records that a request has been raised. A single pending output tells the processor side that at least one unmasked request is waiting.

Lines are driven by one-cycle synchronous raise and drop pulses, and mask vectors come from the surrounding controller. Priority resolution and acknowledge sit outside the block. The acknowledge logic removes one serviced request at a time through a clear port.

Top module: `irqcap_top`

## Requirements
- R1: After reset both request registers are 0, both flags are 0, pending is 0, and both trigger-mode bytes read 0, so every line starts edge-triggered.
- R2: Line n below 8 maps to primary request bit n. Line n of 8 or more maps to secondary request bit n-8. A change is visible on the outputs after the next rising clock edge.
- R3: A raise pulse on a line whose mask bit is 1 has no effect. A raise on an unmasked line sets its request bit and that controller's flag.
- R4: A raise on any unmasked secondary line also sets primary bit 2, the cascade bit, and the primary flag, whatever the primary mask holds.
- R5: A drop pulse clears the request bit only when the line's trigger-mode bit is 1 (level). With trigger-mode bit 0 (edge), the request stays latched.
- R6: When a secondary drop on a level line leaves the secondary request register empty, primary bit 2 is cleared in the same update. While any secondary bit remains set, bit 2 is kept.
- R7: Pending is 1 when either of two conditions holds: a primary request bit other than bit 2 is set with its mask bit 0, or a secondary request bit is set with its mask bit 0.
- R8: Trigger-mode index 0 holds the primary lines and index 1 the secondary lines, with bit k standing for line k of that controller. A write to an index above 1 is ignored. A read of an index above 1 returns 0xFF. The read data is combinational.
- R9: A raise and a drop of the same line in the same cycle leave the request set.
- R10: An acknowledge clear removes only the addressed bit at the next edge. The clear select is 0 for the primary and 1 for the secondary. A raise of that same bit in the same cycle wins.
- R11: A controller's flag clears only when an acknowledge clear on that controller leaves its request register empty. A drop never clears a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_set_i | input | 16 | One-cycle raise pulse per line |
| line_drop_i | input | 16 | One-cycle drop pulse per line |
| mask_pri_i | input | 8 | Primary mask, 1 blocks a line |
| mask_sec_i | input | 8 | Secondary mask, 1 blocks a line |
| cfg_we_i | input | 1 | Trigger-mode write strobe |
| cfg_idx_i | input | 2 | Trigger-mode byte index |
| cfg_wdata_i | input | 8 | Trigger-mode write data |
| cfg_rdata_o | output | 8 | Trigger-mode read data at cfg_idx_i |
| ack_clr_i | input | 1 | Acknowledge clear strobe |
| ack_ctrl_i | input | 1 | Clear target, 0 primary, 1 secondary |
| ack_bit_i | input | 3 | Bit to clear |
| req_pri_o | output | 8 | Primary request register |
| req_sec_o | output | 8 | Secondary request register |
| flag_pri_o | output | 1 | Primary asserted flag |
| flag_sec_o | output | 1 | Secondary asserted flag |
| pending_o | output | 1 | Any unmasked request waiting |

## Verification
The properties assume that raise and drop pulses, the clear strobe and the trigger-mode write are all sampled at the rising edge, and that the masks are held steady across each edge. They also assume that the clear port names a single bit of a single controller per cycle. The bench changes every input only on the falling edge, and it returns the pulse inputs to zero with idle cycles. Its clear requests always carry one controller select and one bit index, so the stimulus stays inside these assumptions.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

   localparam int unsigned DFLT_LINES       = 8;
   localparam int unsigned DFLT_CASCADE_BIT = 2;
   localparam int unsigned DFLT_IDX_W       = 2;
   localparam int unsigned NUM_CTRL         = 2;

   typedef enum logic {
      CTRL_PRI = 1'b0,
      CTRL_SEC = 1'b1
   } ctrl_sel_e;

endpackage

// File: rtl/irqcap_trig_cfg.sv
module irqcap_trig_cfg #(
   parameter int unsigned W     = 8,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned NREGS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [W-1:0]       wdata_i,
   output logic [W-1:0]       rdata_o,
   output logic [NREGS*W-1:0] trig_o
);

   localparam int unsigned SPAN = 1 << IDX_W;

   if (SPAN < NREGS) begin : g_bad_idx
      $error("irqcap_trig_cfg: index width too small for register count");
   end

   logic [W-1:0] rd_mux [SPAN];

   for (genvar r = 0; r < SPAN; r++) begin : g_slot
      if (r < NREGS) begin : g_reg
         logic [W-1:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (we_i && (idx_i == IDX_W'(r))) begin
               byte_q <= wdata_i;
            end
         end
         assign trig_o[r*W +: W] = byte_q;
         assign rd_mux[r]        = byte_q;
      end else begin : g_hole
         assign rd_mux[r] = '1;
      end
   end

   assign rdata_o = rd_mux[idx_i];

endmodule

// File: rtl/irqcap_req_bank.sv
module irqcap_req_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic         ack_hit_i,
   output logic [W-1:0] req_o,
   output logic [W-1:0] req_nxt_o,
   output logic         flag_o
);

   logic [W-1:0] req_q;
   logic         flag_q;
   logic         flag_nxt;

   always_comb begin
      req_nxt_o = (req_q & ~clr_i) | set_i;
      if (|set_i) begin
         flag_nxt = 1'b1;
      end else if (ack_hit_i && (req_nxt_o == '0)) begin
         flag_nxt = 1'b0;
      end else begin
         flag_nxt = flag_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         req_q  <= req_nxt_o;
         flag_q <= flag_nxt;
      end
   end

   assign req_o  = req_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/irqcap_pending.sv
module irqcap_pending #(
   parameter int unsigned W           = 8,
   parameter int unsigned CASCADE_BIT = 2,
   parameter bit          HAS_CASCADE = 1'b0
) (
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] mask_i,
   output logic         any_o
);

   logic [W-1:0] live;

   if (HAS_CASCADE) begin : g_skip_casc
      logic [W-1:0] keep;
      for (genvar b = 0; b < W; b++) begin : g_keep
         assign keep[b] = (b != CASCADE_BIT);
      end
      assign live = req_i & ~mask_i & keep;
   end else begin : g_plain
      assign live = req_i & ~mask_i;
   end

   assign any_o = |live;

endmodule

// File: rtl/irqcap_top.sv
module irqcap_top
   import irqcap_pkg::*;
#(
   parameter int unsigned L           = DFLT_LINES,
   parameter int unsigned CASCADE_BIT = DFLT_CASCADE_BIT,
   parameter int unsigned IDX_W       = DFLT_IDX_W,
   localparam int unsigned N          = NUM_CTRL * L,
   localparam int unsigned BIT_W      = (L > 1) ? $clog2(L) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     line_set_i,
   input  logic [N-1:0]     line_drop_i,
   input  logic [L-1:0]     mask_pri_i,
   input  logic [L-1:0]     mask_sec_i,
   input  logic             cfg_we_i,
   input  logic [IDX_W-1:0] cfg_idx_i,
   input  logic [L-1:0]     cfg_wdata_i,
   output logic [L-1:0]     cfg_rdata_o,
   input  logic             ack_clr_i,
   input  logic             ack_ctrl_i,
   input  logic [BIT_W-1:0] ack_bit_i,
   output logic [L-1:0]     req_pri_o,
   output logic [L-1:0]     req_sec_o,
   output logic             flag_pri_o,
   output logic             flag_sec_o,
   output logic             pending_o
);

   if (L < 2 || CASCADE_BIT >= L) begin : g_bad_cfg
      $error("irqcap_top: cascade bit must lie inside a controller of two or more lines");
   end

   logic [N-1:0] trig_flat;
   logic [L-1:0] trig_pri, trig_sec;

   irqcap_trig_cfg #(
      .W     (L),
      .IDX_W (IDX_W),
      .NREGS (NUM_CTRL)
   ) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .idx_i   (cfg_idx_i),
      .wdata_i (cfg_wdata_i),
      .rdata_o (cfg_rdata_o),
      .trig_o  (trig_flat)
   );

   assign trig_pri = trig_flat[L-1:0];
   assign trig_sec = trig_flat[N-1:L];

   logic         ack_pri_hit, ack_sec_hit;
   logic [L-1:0] ack_pri_vec, ack_sec_vec;

   assign ack_pri_hit = ack_clr_i && (ctrl_sel_e'(ack_ctrl_i) == CTRL_PRI);
   assign ack_sec_hit = ack_clr_i && (ctrl_sel_e'(ack_ctrl_i) == CTRL_SEC);

   for (genvar b = 0; b < L; b++) begin : g_ack
      assign ack_pri_vec[b] = ack_pri_hit && (ack_bit_i == BIT_W'(b));
      assign ack_sec_vec[b] = ack_sec_hit && (ack_bit_i == BIT_W'(b));
   end

   logic [L-1:0] sec_set, sec_lvl_drop, sec_clr, sec_nxt;

   assign sec_set      = line_set_i[N-1:L] & ~mask_sec_i;
   assign sec_lvl_drop = line_drop_i[N-1:L] & trig_sec;
   assign sec_clr      = sec_lvl_drop | ack_sec_vec;

   irqcap_req_bank #(.W(L)) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (sec_set),
      .clr_i     (sec_clr),
      .ack_hit_i (ack_sec_hit),
      .req_o     (req_sec_o),
      .req_nxt_o (sec_nxt),
      .flag_o    (flag_sec_o)
   );

   logic         casc_raise, casc_drop;
   logic [L-1:0] casc_set_vec, casc_clr_vec;

   assign casc_raise = |sec_set;
   assign casc_drop  = (|sec_lvl_drop) && (sec_nxt == '0);

   for (genvar b = 0; b < L; b++) begin : g_casc
      if (b == CASCADE_BIT) begin : g_tap
         assign casc_set_vec[b] = casc_raise;
         assign casc_clr_vec[b] = casc_drop;
      end else begin : g_none
         assign casc_set_vec[b] = 1'b0;
         assign casc_clr_vec[b] = 1'b0;
      end
   end

   logic [L-1:0] pri_set, pri_clr, pri_nxt;

   assign pri_set = (line_set_i[L-1:0] & ~mask_pri_i) | casc_set_vec;
   assign pri_clr = (line_drop_i[L-1:0] & trig_pri) | ack_pri_vec | casc_clr_vec;

   irqcap_req_bank #(.W(L)) u_pri (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (pri_set),
      .clr_i     (pri_clr),
      .ack_hit_i (ack_pri_hit),
      .req_o     (req_pri_o),
      .req_nxt_o (pri_nxt),
      .flag_o    (flag_pri_o)
   );

   logic pend_pri, pend_sec;

   irqcap_pending #(
      .W           (L),
      .CASCADE_BIT (CASCADE_BIT),
      .HAS_CASCADE (1'b1)
   ) u_pend_pri (
      .req_i  (req_pri_o),
      .mask_i (mask_pri_i),
      .any_o  (pend_pri)
   );

   irqcap_pending #(
      .W           (L),
      .CASCADE_BIT (CASCADE_BIT),
      .HAS_CASCADE (1'b0)
   ) u_pend_sec (
      .req_i  (req_sec_o),
      .mask_i (mask_sec_i),
      .any_o  (pend_sec)
   );

   assign pending_o = pend_pri | pend_sec;

endmodule

// File: rtl/irqcap_chk.sv
module irqcap_chk #(
   parameter int unsigned L           = 8,
   parameter int unsigned CASCADE_BIT = 2,
   parameter int unsigned IDX_W       = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2*L-1:0]   line_set_i,
   input logic [L-1:0]     mask_pri_i,
   input logic [L-1:0]     mask_sec_i,
   input logic             ack_clr_i,
   input logic             ack_ctrl_i,
   input logic [IDX_W-1:0] cfg_idx_i,
   input logic [L-1:0]     cfg_rdata_o,
   input logic [L-1:0]     req_pri_o,
   input logic [L-1:0]     req_sec_o,
   input logic             flag_pri_o,
   input logic             flag_sec_o,
   input logic             pending_o,
   input logic [L-1:0]     trig_sec
);

   localparam logic [L-1:0] CASC = L'(1) << CASCADE_BIT;

   logic [L-1:0] sec_raise;
   assign sec_raise = line_set_i[2*L-1:L] & ~mask_sec_i;

   // R3: masked raises on non-cascade primary lines leave the bit clear
   p_masked_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((req_pri_o & $past(line_set_i[L-1:0] & mask_pri_i & ~req_pri_o & ~CASC)) == '0));

   // R3: unmasked secondary raises land in the secondary register
   p_unmasked_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|sec_raise) |=> (((req_sec_o & $past(sec_raise)) == $past(sec_raise)) && flag_sec_o));

   // R4: secondary activity reaches the primary cascade bit
   p_cascade_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|sec_raise) |=> ((req_pri_o & CASC) == CASC) && flag_pri_o);

   // R5: edge-mode secondary requests survive without a secondary clear
   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_clr_i && ack_ctrl_i) |=>
         ((req_sec_o & $past(req_sec_o & ~trig_sec)) == $past(req_sec_o & ~trig_sec)));

   // R7: pending needs some request to be present
   p_pending_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o |-> ((req_pri_o != '0) || (req_sec_o != '0)));

   // R11: a nonempty register always has its flag up
   p_flag_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_pri_o != '0) |-> flag_pri_o);
   p_flag_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sec_o != '0) |-> flag_sec_o);

   // R8: indices past the store read as all ones
   p_hole_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx_i > IDX_W'(1)) |-> (cfg_rdata_o == '1));

endmodule

bind irqcap_top irqcap_chk #(
   .L           (L),
   .CASCADE_BIT (CASCADE_BIT),
   .IDX_W       (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_set_i  (line_set_i),
   .mask_pri_i  (mask_pri_i),
   .mask_sec_i  (mask_sec_i),
   .ack_clr_i   (ack_clr_i),
   .ack_ctrl_i  (ack_ctrl_i),
   .cfg_idx_i   (cfg_idx_i),
   .cfg_rdata_o (cfg_rdata_o),
   .req_pri_o   (req_pri_o),
   .req_sec_o   (req_sec_o),
   .flag_pri_o  (flag_pri_o),
   .flag_sec_o  (flag_sec_o),
   .pending_o   (pending_o),
   .trig_sec    (trig_sec)
);

// File: tb/sim_irqcap_top.sv
`timescale 1ns/1ps
module sim_irqcap_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] line_set = '0, line_drop = '0;
   logic [7:0]  mask_pri = '0, mask_sec = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0, cfg_rdata;
   logic        ack_clr = 1'b0, ack_ctrl = 1'b0;
   logic [2:0]  ack_bit = '0;
   logic [7:0]  req_pri, req_sec;
   logic        flag_pri, flag_sec, pending;

   always #2.5 clk = ~clk;

   irqcap_top u0 (
      .clk(clk), .rst_n(rst_n),
      .line_set_i(line_set), .line_drop_i(line_drop),
      .mask_pri_i(mask_pri), .mask_sec_i(mask_sec),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata),
      .ack_clr_i(ack_clr), .ack_ctrl_i(ack_ctrl), .ack_bit_i(ack_bit),
      .req_pri_o(req_pri), .req_sec_o(req_sec),
      .flag_pri_o(flag_pri), .flag_sec_o(flag_sec), .pending_o(pending)
   );

   typedef struct {
      string      tag;
      logic [7:0] p, s;
      logic       fp, fs, pend;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0, n_bad = 0;
   bit   done = 1'b0;

   // model state, built from the requirements
   logic [7:0] m_p = '0, m_s = '0, m_t0 = '0, m_t1 = '0;
   logic       m_fp = 1'b0, m_fs = 1'b0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(string tag, logic [15:0] set, logic [15:0] drop,
                        logic [7:0] mp, logic [7:0] ms,
                        bit we, logic [1:0] idx, logic [7:0] wd,
                        bit ack, bit actl, logic [2:0] abit);
      logic [7:0] sset, sdrop, sack, pset, pclr, pack, ns, np;
      exp_t e;
      @(negedge clk);
      line_set = set; line_drop = drop; mask_pri = mp; mask_sec = ms;
      cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
      ack_clr = ack; ack_ctrl = actl; ack_bit = abit;
      sset  = set[15:8] & ~ms;
      sdrop = drop[15:8] & m_t1;
      sack  = (ack && actl) ? (8'h01 << abit) : 8'h00;
      pack  = (ack && !actl) ? (8'h01 << abit) : 8'h00;
      ns    = (m_s & ~(sdrop | sack)) | sset;
      pset  = (set[7:0] & ~mp) | ((sset != 0) ? 8'h04 : 8'h00);
      pclr  = (drop[7:0] & m_t0) | pack | (((sdrop != 0) && (ns == 0)) ? 8'h04 : 8'h00);
      np    = (m_p & ~pclr) | pset;
      if (pset != 0) m_fp = 1'b1;
      else if (ack && !actl && np == 0) m_fp = 1'b0;
      if (sset != 0) m_fs = 1'b1;
      else if (ack && actl && ns == 0) m_fs = 1'b0;
      if (we && idx == 2'd0) m_t0 = wd;
      if (we && idx == 2'd1) m_t1 = wd;
      m_p = np; m_s = ns;
      e.tag = tag; e.p = np; e.s = ns; e.fp = m_fp; e.fs = m_fs;
      e.pend = ((np & ~mp & 8'hFB) != 0) || ((ns & ~ms) != 0);
      exp_q.push_back(e);
   endtask

   task automatic idle(string tag);
      drive(tag, '0, '0, mask_pri, mask_sec, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic raise(string tag, logic [15:0] set);
      drive(tag, set, '0, mask_pri, mask_sec, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic drop(string tag, logic [15:0] d);
      drive(tag, '0, d, mask_pri, mask_sec, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic ack_one(string tag, bit actl, logic [2:0] b);
      drive(tag, '0, '0, mask_pri, mask_sec, 0, 0, 0, 1, actl, b);
   endtask

   task automatic cfg_write(string tag, logic [1:0] idx, logic [7:0] wd);
      drive(tag, '0, '0, mask_pri, mask_sec, 1, idx, wd, 0, 0, 0);
   endtask

   task automatic cfg_read(string tag, logic [1:0] idx, logic [7:0] exp);
      @(negedge clk);
      line_set = '0; line_drop = '0; cfg_we = 0; ack_clr = 0; cfg_idx = idx;
      #1;
      check(tag, cfg_rdata, exp);
   endtask

   // monitor: compare one expected item per edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " req_pri"}, req_pri, e.p);
            check({e.tag, " req_sec"}, req_sec, e.s);
            check({e.tag, " flags"}, {flag_pri, flag_sec}, {e.fp, e.fs});
            check({e.tag, " pending"}, pending, e.pend);
         end
      end
   end

   initial begin
      #20;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 req_pri", req_pri, 0);
      check("R1 req_sec", req_sec, 0);
      check("R1 flags", {flag_pri, flag_sec}, 0);
      check("R1 pending", pending, 0);
      cfg_read("R1 trig0", 2'd0, 8'h00);
      cfg_read("R1 trig1", 2'd1, 8'h00);

      // R2 line mapping, R4 cascade
      raise("R2 lines5_11", 16'h0820);
      raise("R4 line13", 16'h2000);
      // R3 masked lines ignored
      drive("R3 masked", 16'h0102, '0, 8'h02, 8'h01, 0, 0, 0, 0, 0, 0);
      drive("R3 masked pri2", 16'h0004, '0, 8'h04, 8'h00, 0, 0, 0, 0, 0, 0);
      drive("R3 unmask", '0, '0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0);

      // R8 trigger-mode store
      cfg_write("R8 wr0", 2'd0, 8'h01);
      cfg_write("R8 wr1", 2'd1, 8'h02);
      cfg_write("R8 wr2 ignored", 2'd2, 8'h55);
      cfg_read("R8 rd0", 2'd0, 8'h01);
      cfg_read("R8 rd1", 2'd1, 8'h02);
      cfg_read("R8 rd2", 2'd2, 8'hFF);
      cfg_read("R8 rd3", 2'd3, 8'hFF);

      // R5 level vs edge drops; R6 negative: secondary still busy
      raise("R5 lines0_9", 16'h0201);
      drop("R5 drop0_5_9_11", 16'h0A21);
      // R10 clear secondary bits, R11 flag falls when empty
      ack_one("R10 ack sec3", 1, 3'd3);
      ack_one("R11 ack sec5", 1, 3'd5);
      ack_one("R10 ack pri2", 0, 3'd2);

      // R6 level drop empties secondary
      raise("R6 line9", 16'h0200);
      drop("R6 drop9", 16'h0200);
      drop("R11 drop keeps flag", 16'h0200);

      // R9 raise and drop together
      drive("R9 both line0", 16'h0001, 16'h0001, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0);
      // R10 clear vs raise of same bit
      drive("R10 raise wins", 16'h0001, '0, 8'h00, 8'h00, 0, 0, 0, 1, 0, 3'd0);
      ack_one("R10 ack pri0", 0, 3'd0);

      // R7 pending excludes cascade bit and masked lines
      ack_one("R7 clear5", 0, 3'd5);
      raise("R7 line12", 16'h1000);
      ack_one("R7 ack sec4", 1, 3'd4);
      raise("R7 line3", 16'h0008);
      drive("R7 mask3", '0, '0, 8'h08, 8'h00, 0, 0, 0, 0, 0, 0);
      drive("R7 sec masked", 16'h4000, '0, 8'h08, 8'h40, 0, 0, 0, 0, 0, 0);
      drive("R7 sec masked raise", 16'h0100, '0, 8'h08, 8'h01, 0, 0, 0, 0, 0, 0);
      drive("R7 sec unmask", '0, '0, 8'h08, 8'h00, 0, 0, 0, 0, 0, 0);
      idle("R11 idle");
      idle("final idle");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule